// File: doc/BRIEF.md
# Two-Set Four-Way Tag Directory with FIFO Replacement

This block models only the tag side of a small set-associative cache. A client
sends one block number per accepted lookup. The block answers hit or miss one
cycle later. It also keeps two running counters, total lookups and hits, so the
hit ratio can be read out as `hit_count / access_count`. It holds no data and
does no refill timing or write handling. A miss installs the block's tag at once.

With the default parameters the directory has two sets of four ways. The set is
chosen by bit 2 of the 4-bit block number, so runs of four consecutive block
numbers go to the sets in turn. The stored tag is the block number with that bit
removed. Inside a set, a missing block takes the lowest-numbered empty way. Once
the set is full, the block that was installed earliest is replaced, and it is
replaced in its own way position. Hits never change the replacement order.

Top module: `sa_tag_directory`

## Requirements
- R1: The set index is bit 2 of the block number. Blocks 0-3 and 8-11 use set 0, and blocks 4-7 and 12-15 use set 1. Lookups in one set never evict a block from the other set.
- R2: A lookup of a block that is resident in its set reports `rsp_hit`=1 and leaves the contents of the set unchanged.
- R3: A miss into a set that has an empty way installs the block with no eviction. After reset, the first four distinct blocks that miss into a set all stay resident together.
- R4: A miss into a full set evicts the block installed earliest in that set, whatever hits came in between. The oldest block is then installed after the others.
- R5: A lookup is accepted in a cycle where `lk_valid` and `lk_ready` are both high. Exactly one cycle later `rsp_valid` is 1 and `rsp_hit` gives the result. In every other cycle `rsp_valid` and `rsp_hit` are 0.
- R6: `access_count` goes up by one for each accepted lookup, and `hit_count` goes up by one for each hit. Both change in the same cycle as the matching `rsp_valid`. They hold their value in cycles without a response.
- R7: While `rst` is high (synchronous, active high), `lk_ready` is 0. In the cycle after a reset edge, both counters and `rsp_valid` are 0. A reset empties every set, so no earlier block hits afterwards.
- R8: After reset is released, `lk_ready` stays 1. Lookups sent back to back, one per cycle, are answered in order, and each one sees the installs made by the lookups before it.
- R9: From reset, the block sequence 2 5 0 13 2 5 10 8 0 4 5 2 gives hits only at positions 5, 6, 9, 11 and 12. That is 5 hits out of 12 lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Directory can accept a lookup |
| lk_block | input | BLK_W (4) | Block number to look up |
| rsp_valid | output | 1 | Result of the lookup accepted in the previous cycle |
| rsp_hit | output | 1 | That lookup was a hit |
| access_count | output | CNT_W (16) | Number of lookups accepted since reset |
| hit_count | output | CNT_W (16) | Number of hits since reset |

## Verification
The bench builds the directory with its default parameters: 4-bit block numbers, the index at bit 2, two sets of four ways and 16-bit counters. With only sixteen block numbers, random traffic keeps coming back to blocks that are resident. It fills both sets many times over, so eviction wraps and repeated evictions of the same way happen often, next to the directed fill, FIFO-order, trace and reset cases. Every cycle is compared with a queue-per-set model in the bench. This also covers idle gaps and back-to-back lookups.

// File: rtl/sa_tag_pkg.sv
package sa_tag_pkg;
  // What a set does with an accepted lookup
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_HIT   = 2'd1,
    ACT_FILL  = 2'd2,
    ACT_EVICT = 2'd3
  } set_act_e;
endpackage

// File: rtl/sa_set_map.sv
// Splits a block number into a set index and a tag.
// The tag keeps every bit of the block number except the index field.
module sa_set_map #(
  parameter int BLK_W   = 4,
  parameter int SET_LSB = 2,
  parameter int SET_W   = 1,
  localparam int TAG_W  = BLK_W - SET_W
) (
  input  logic [BLK_W-1:0] blk,
  output logic [SET_W-1:0] set_idx,
  output logic [TAG_W-1:0] tag
);
  assign set_idx = blk[SET_LSB +: SET_W];
  assign tag     = {blk[BLK_W-1:SET_LSB+SET_W], blk[SET_LSB-1:0]};
endmodule

// File: rtl/sa_tag_set.sv
// One set: way tags, valid bits and a FIFO replacement pointer.
module sa_tag_set
  import sa_tag_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 3,
  localparam int PTR_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit
);
  logic [TAG_W-1:0] tag_mem [WAYS];
  logic [WAYS-1:0]  vld;
  logic [WAYS-1:0]  match;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] empty_idx;
  logic [PTR_W-1:0] wr_idx;
  logic             full;
  set_act_e         act;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tag_mem[w] == lk_tag);
  end

  assign hit  = |match;
  assign full = &vld;

  // Lowest empty way: scan from the top so the lowest index is chosen last
  always_comb begin
    empty_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) empty_idx = PTR_W'(w);
    end
  end

  always_comb begin
    if (!lk_en)     act = ACT_IDLE;
    else if (hit)   act = ACT_HIT;
    else if (!full) act = ACT_FILL;
    else            act = ACT_EVICT;
  end

  assign wr_idx = (act == ACT_FILL) ? empty_idx : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      case (act)
        ACT_FILL:  vld[empty_idx] <= 1'b1;
        ACT_EVICT: ptr <= (ptr == PTR_W'(WAYS - 1)) ? '0 : ptr + 1'b1;
        default: ;
      endcase
    end
  end

  // Tag array with no reset, so it can map onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (act == ACT_FILL || act == ACT_EVICT) tag_mem[wr_idx] <= lk_tag;
  end
endmodule

// File: rtl/sa_lookup_stats.sv
// Registered response and the running access/hit counters.
module sa_lookup_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             hit,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] access_count,
  output logic [CNT_W-1:0] hit_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      access_count <= '0;
      hit_count    <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= accept && hit;
      if (accept) access_count <= access_count + 1'b1;
      if (accept && hit) hit_count <= hit_count + 1'b1;
    end
  end
endmodule

// File: rtl/sa_tag_directory.sv
module sa_tag_directory #(
  parameter int BLK_W   = 4,
  parameter int SET_LSB = 2,
  parameter int SET_W   = 1,
  parameter int WAYS    = 4,
  parameter int CNT_W   = 16,
  localparam int TAG_W  = BLK_W - SET_W,
  localparam int SETS   = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [BLK_W-1:0] lk_block,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] access_count,
  output logic [CNT_W-1:0] hit_count
);
  logic             ready_q;
  logic             accept;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [SETS-1:0]  set_hit;

  always_ff @(posedge clk) ready_q <= !rst;

  assign lk_ready = ready_q;
  assign accept   = lk_valid && ready_q;

  sa_set_map #(.BLK_W(BLK_W), .SET_LSB(SET_LSB), .SET_W(SET_W)) u_map (
    .blk(lk_block), .set_idx(set_idx), .tag(tag)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set
    sa_tag_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
      .clk(clk), .rst(rst),
      .lk_en(accept && (set_idx == SET_W'(s))),
      .lk_tag(tag),
      .hit(set_hit[s])
    );
  end

  sa_lookup_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .accept(accept), .hit(set_hit[set_idx]),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .access_count(access_count), .hit_count(hit_count)
  );
endmodule

// File: rtl/sa_tag_directory_chk.sv
module sa_tag_directory_chk #(
  parameter int BLK_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [BLK_W-1:0] lk_block,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] access_count,
  input logic [CNT_W-1:0] hit_count
);
  logic             prev_acc;
  logic [BLK_W-1:0] prev_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_acc <= 1'b0;
      prev_blk <= '0;
    end else begin
      prev_acc <= lk_valid && lk_ready;
      prev_blk <= lk_block;
    end
  end

  // R2: the same block accepted in two cycles in a row must hit the second time
  assert_repeat_hits_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && prev_acc && lk_block == prev_blk) |=> rsp_hit);

  assert_rsp_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_ready) |=> !rsp_valid);

  assert_hit_needs_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  assert_access_step_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> access_count == $past(access_count) + 1'b1);

  assert_counters_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ($stable(access_count) && $stable(hit_count)));

  assert_hit_step_R6: assert property (@(posedge clk) disable iff (rst)
    $changed(hit_count) |-> rsp_hit);

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (access_count == '0 && hit_count == '0 && !rsp_valid));

  assert_not_ready_in_reset_R7: assert property (@(posedge clk)
    rst |=> !lk_ready);
endmodule

bind sa_tag_directory sa_tag_directory_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_block(lk_block), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .access_count(access_count), .hit_count(hit_count)
);

// File: tb/sa_tag_directory_test.sv
`timescale 1ns/1ps
module sa_tag_directory_test;
  localparam int BLK_W = 4;
  localparam int CNT_W = 16;
  localparam int WAYS  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic [BLK_W-1:0] lk_block = '0;
  logic             lk_ready, rsp_valid, rsp_hit;
  logic [CNT_W-1:0] access_count, hit_count;

  always #2 clk = ~clk;  // 250 MHz

  sa_tag_directory uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_block(lk_block), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .access_count(access_count), .hit_count(hit_count)
  );

  int errors = 0;
  int checks = 0;
  string req = "R8";

  // Reference model: one FIFO queue of resident blocks per set
  int set0_q[$];
  int set1_q[$];
  bit exp_valid = 0, exp_hit = 0;
  int exp_acc = 0, exp_hits = 0;
  bit obs_hits[$];

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic model_reset();
    set0_q.delete(); set1_q.delete();
    exp_valid = 0; exp_hit = 0; exp_acc = 0; exp_hits = 0;
  endtask

  function automatic bit model_lookup(input int b);
    bit h = 0;
    if (b[2] == 1'b0) begin
      foreach (set0_q[i]) if (set0_q[i] == b) h = 1;
      if (!h) begin
        if (set0_q.size() == WAYS) void'(set0_q.pop_front());
        set0_q.push_back(b);
      end
    end else begin
      foreach (set1_q[i]) if (set1_q[i] == b) h = 1;
      if (!h) begin
        if (set1_q.size() == WAYS) void'(set1_q.pop_front());
        set1_q.push_back(b);
      end
    end
    return h;
  endfunction

  // One cycle: compare outputs at the falling edge, then drive the next request
  task automatic step(input bit v, input int b);
    @(negedge clk);
    chk("R8", "lk_ready", lk_ready, 1);
    chk("R5", "rsp_valid", rsp_valid, exp_valid);
    chk(req, "rsp_hit", rsp_hit, exp_hit);
    chk("R6", "access_count", access_count, exp_acc);
    chk("R6", "hit_count", hit_count, exp_hits);
    if (rsp_valid) obs_hits.push_back(rsp_hit);
    lk_valid = v;
    lk_block = BLK_W'(b);
    exp_valid = v;
    exp_hit = v ? model_lookup(b) : 1'b0;
    if (v) begin
      exp_acc++;
      if (exp_hit) exp_hits++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lk_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "lk_ready in reset", lk_ready, 0);
    chk("R7", "access_count in reset", access_count, 0);
    chk("R7", "hit_count in reset", hit_count, 0);
    chk("R7", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    model_reset();
    obs_hits.delete();
  endtask

  // Send a block and check the hit result directly when it comes back
  task automatic probe(input int b, input bit want, input string r);
    step(1, b);
    step(0, 0);
    chk(r, $sformatf("hit for block %0d", b), obs_hits[$], want);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R9: fixed trace, back to back
    req = "R9";
    begin
      int trace[12] = '{2, 5, 0, 13, 2, 5, 10, 8, 0, 4, 5, 2};
      bit want[12]  = '{0, 0, 0, 0, 1, 1, 0, 0, 1, 0, 1, 1};
      foreach (trace[i]) step(1, trace[i]);
      step(0, 0);
      chk("R9", "trace responses", obs_hits.size(), 12);
      foreach (want[i])
        if (i < obs_hits.size())
          chk("R9", $sformatf("trace hit at pos %0d", i + 1), obs_hits[i], want[i]);
      chk("R9", "trace hit_count", hit_count, 5);
      chk("R9", "trace access_count", access_count, 12);
    end

    // R7: reset empties the sets
    do_reset();
    req = "R7";
    probe(2, 0, "R7");

    // R1 / R3: fill set 0 with 0..3, then set 1 with 4..7; set 0 stays intact
    do_reset();
    req = "R3";
    for (int b = 0; b < 4; b++) probe(b, 0, "R3");
    for (int b = 0; b < 4; b++) probe(b, 1, "R3");
    req = "R1";
    for (int b = 4; b < 8; b++) probe(b, 0, "R1");
    for (int b = 0; b < 4; b++) probe(b, 1, "R1");
    probe(12, 0, "R1");  // set 1 evicts 4
    probe(0, 1, "R1");
    probe(4, 0, "R1");

    // R4 / R2: hits on the oldest block do not save it from eviction
    do_reset();
    req = "R4";
    for (int b = 0; b < 4; b++) step(1, b);
    probe(0, 1, "R2");
    probe(0, 1, "R2");
    probe(8, 0, "R4");   // evicts 0
    probe(1, 1, "R4");
    probe(0, 0, "R4");   // evicts 1
    probe(1, 0, "R4");   // evicts 2
    probe(3, 1, "R4");

    // R5 / R8: random traffic with gaps and back-to-back runs
    do_reset();
    req = "R8";
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, $urandom % 16);
    step(0, 0);
    step(0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule